// File: doc/BRIEF.md
# PWM Rising-Edge Dead-Time Inserter

This block takes one PWM waveform and produces a copy whose rising edges are held back by a programmable number of clock cycles. Falling edges pass straight through. Half-bridge drive stages use this to leave a gap between one switch turning off and its partner turning on. When the generator is disabled, the input reaches the output unchanged.

Software writes the delay into a shadow register. The update-mode select decides when the shadow value becomes the active delay:

- **Immediate:** the value is used at once.
- **Local:** the value is used at the next counter-zero strobe from the PWM counter.
- **Global:** the value is used at the first counter-zero strobe after a global update request has been latched.

A later write replaces a shadow value that has not yet been applied, so the replaced value is never used.

Top module: `pwm_rise_deadband`

## Requirements
- R1: While `rst_n` is low, `pwm_out` is low. Reset leaves the active delay and the shadow delay at zero and clears the latched global request.
- R2: With the generator enabled and an active delay D, `pwm_out` rises D clock cycles after `pwm_in` rises. The cycle in which `pwm_in` first reads high is cycle 0, and the output is first high in cycle D.
- R3: `pwm_out` falls in the same cycle that `pwm_in` falls. The output is never high while the input is low.
- R4: If an input high pulse lasts D cycles or fewer, `pwm_out` stays low for the whole of that pulse.
- R5: With `db_en` low, `pwm_out` equals `pwm_in` whatever the delay setting.
- R6: An active delay of zero makes `pwm_out` equal `pwm_in` with no added cycles.
- R7: With `upd_mode` = 2'b00 (immediate), a write updates both the shadow and the active delay on that clock edge.
- R8: With `upd_mode` = 2'b01 (local), a write updates only the shadow. The shadow is copied into the active delay on the edge where `cnt_zero` is high.
- R9: With `upd_mode[1]` = 1 (global), `cnt_zero` updates the active delay only when a `gsync_req` pulse has been latched on an earlier edge.
- R10: A second write before the update is applied replaces the shadow value. The first value never reaches the active delay.
- R11: The latched global request is cleared when it is used. A later counter-zero strobe with no new request leaves the active delay unchanged.
- R12: If `pwm_in` falls during the delay countdown, the count is discarded. The next rising edge starts a full new delay of D cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_in | input | 1 | PWM waveform to be delayed |
| db_en | input | 1 | Enables the dead-time generator; when low, the input is passed through |
| cnt_zero | input | 1 | One-cycle strobe marking the PWM counter at zero |
| gsync_req | input | 1 | One-cycle global update request |
| wr_en | input | 1 | Write strobe for the delay register |
| wr_data | input | DLY_W | Delay value in clock cycles |
| upd_mode | input | 2 | 00 immediate, 01 local, 1x global |
| pwm_out | output | 1 | Output waveform with delayed rising edges |

## Verification
Pulses wider than the delay check that the rising edge lands in exactly cycle D and that the falling edge is not delayed. Pulses of exactly D cycles and of fewer than D cycles check that the output is fully suppressed. A short pulse followed at once by a long one shows whether the countdown restarts or continues from where it stopped. Write, strobe and request sequences in each update mode are each followed by a test pulse, which separates an applied delay from one still pending, an overwritten shadow value from the value that replaced it, and a request that has been used from one still latched.

// File: rtl/pwm_rise_deadband.sv
module pwm_rise_deadband #(
  parameter int DLY_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             db_en,
  input  logic             cnt_zero,
  input  logic             gsync_req,
  input  logic             wr_en,
  input  logic [DLY_W-1:0] wr_data,
  input  logic [1:0]       upd_mode,
  output logic             pwm_out
);
  localparam logic [1:0] MODE_IMM = 2'b00;
  localparam logic [1:0] MODE_LOC = 2'b01;

  logic [DLY_W-1:0] active_q, shadow_q, cnt_q;
  logic             gflag_q;
  logic             apply_loc, apply_glb, rise_ok;

  assign apply_loc = (upd_mode == MODE_LOC) && cnt_zero;
  assign apply_glb = upd_mode[1] && cnt_zero && gflag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      gflag_q  <= 1'b0;
    end else begin
      if (wr_en)
        shadow_q <= wr_data;
      if (wr_en && upd_mode == MODE_IMM)
        active_q <= wr_data;
      else if (apply_loc || apply_glb)
        active_q <= shadow_q;
      gflag_q <= gsync_req | (gflag_q & ~apply_glb);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!pwm_in)
      cnt_q <= '0;
    else if (cnt_q != {DLY_W{1'b1}})
      cnt_q <= cnt_q + 1'b1;
  end

  assign rise_ok = cnt_q >= active_q;
  assign pwm_out = rst_n & pwm_in & (~db_en | rise_ok);
endmodule

// File: rtl/pwm_rise_deadband_chk.sv
module pwm_rise_deadband_chk #(
  parameter int DLY_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_in,
  input logic             pwm_out,
  input logic             db_en,
  input logic             cnt_zero,
  input logic             gsync_req,
  input logic             wr_en,
  input logic [DLY_W-1:0] wr_data,
  input logic [1:0]       upd_mode,
  input logic [DLY_W-1:0] active,
  input logic [DLY_W-1:0] shadow,
  input logic             gflag
);
  always_comb begin
    if (!rst_n) p_reset_low_r1: assert (!pwm_out);
  end

  p_out_needs_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_out |-> pwm_in);

  p_zero_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (db_en && active == '0) |-> (pwm_out == pwm_in));

  p_imm_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && upd_mode == 2'b00) |=> (active == $past(wr_data)));

  p_local_apply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_mode == 2'b01 && cnt_zero) |=> (active == $past(shadow)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !cnt_zero) |=> $stable(active));

  p_glb_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_mode[1] && cnt_zero && !gflag && !wr_en) |=> $stable(active));

  p_glb_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_mode[1] && cnt_zero && gflag && !gsync_req) |=> !gflag);
endmodule

bind pwm_rise_deadband pwm_rise_deadband_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .pwm_out(pwm_out),
  .db_en(db_en), .cnt_zero(cnt_zero), .gsync_req(gsync_req),
  .wr_en(wr_en), .wr_data(wr_data), .upd_mode(upd_mode),
  .active(active_q), .shadow(shadow_q), .gflag(gflag_q)
);

// File: tb/pwm_rise_deadband_test.sv
module pwm_rise_deadband_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  logic clk = 1'b0, rst_n = 1'b0, pwm_in = 1'b0, db_en = 1'b0;
  logic cnt_zero = 1'b0, gsync_req = 1'b0, wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] upd_mode = 2'b00;
  logic pwm_out;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_rise_deadband #(.DLY_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .db_en(db_en),
    .cnt_zero(cnt_zero), .gsync_req(gsync_req), .wr_en(wr_en),
    .wr_data(wr_data), .upd_mode(upd_mode), .pwm_out(pwm_out)
  );

  task automatic chk(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: pwm_out=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse(int d, int w, string tag);
    for (int k = 0; k < w; k++) begin
      pwm_in = 1'b1; #2;
      chk(pwm_out, (k >= d), tag);
      tick();
    end
    pwm_in = 1'b0; #2;
    chk(pwm_out, 1'b0, {tag, " R3 fall"});
    tick();
  endtask

  task automatic wr(int v);
    wr_en = 1'b1; wr_data = DW'(v); tick(); wr_en = 1'b0;
  endtask

  task automatic zero_strobe();
    cnt_zero = 1'b1; tick(); cnt_zero = 1'b0;
  endtask

  task automatic greq();
    gsync_req = 1'b1; tick(); gsync_req = 1'b0;
  endtask

  task automatic t_reset();
    pwm_in = 1'b1; db_en = 1'b1; #2;
    chk(pwm_out, 1'b0, "R1 reset low");
    tick(); pwm_in = 1'b0; rst_n = 1'b1; tick();
    pulse(0, 3, "R1 reset delay zero");
  endtask

  task automatic t_zero();
    pulse(0, 4, "R6 zero delay");
  endtask

  task automatic t_imm();
    upd_mode = 2'b00; wr(3);
    pulse(3, 8, "R2 R7 immediate delay 3");
  endtask

  task automatic t_bypass();
    db_en = 1'b0;
    pulse(0, 3, "R5 disabled passthrough");
    db_en = 1'b1;
  endtask

  task automatic t_short();
    wr(5);
    pulse(5, 5, "R4 pulse equal delay");
    pulse(5, 3, "R4 pulse shorter");
  endtask

  task automatic t_cancel();
    wr(6);
    pulse(6, 3, "R12 aborted countdown");
    pulse(6, 9, "R12 restart full delay");
  endtask

  task automatic t_local();
    upd_mode = 2'b01; wr(2);
    pulse(6, 8, "R8 local pending");
    zero_strobe();
    pulse(2, 5, "R8 local applied");
  endtask

  task automatic t_over();
    wr(9); wr(4); zero_strobe();
    pulse(4, 7, "R10 overwrite applied");
    zero_strobe();
    pulse(4, 7, "R10 first value discarded");
  endtask

  task automatic t_global();
    upd_mode = 2'b10; wr(1);
    zero_strobe();
    pulse(4, 6, "R9 zero without request");
    greq();
    pulse(4, 6, "R9 request without zero");
    zero_strobe();
    pulse(1, 4, "R9 global applied");
    wr(7); zero_strobe();
    pulse(1, 4, "R11 request consumed");
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: expired=1 expected=0");
    finish_up();
  end

  initial begin
    @(posedge clk); #1;
    t_reset();
    t_zero();
    t_imm();
    t_bypass();
    t_short();
    t_cancel();
    t_local();
    t_over();
    t_global();
    finish_up();
  end
endmodule